// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller with Skip Polling

This block collects interrupt events for a small 4-bit processor core. Seven sources feed it: two external pins, four timer underflow strobes and one A/D completion strobe. Each source has a sticky request flag. The flag is set whenever the source's event occurs, whatever the masking state. Each source also has an enable bit, and one global enable flag gates all of them. When a source has its flag set, its enable bit set and the global flag set, the block raises a request toward the core and presents that source's vector address. The core answers with a one-cycle acknowledge.

A source whose enable bit is cleared is in polling mode. Software asks about it with a skip-test query, and the answer comes back in the same cycle. A set flag answers "skip" and is consumed by the query. A source whose enable bit is set never answers a skip-test query.

External pins are asynchronous. Each pin passes through a two-flop synchronizer, and both a rising and a falling level change count as an event.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, every request flag is clear, every enable bit is 0 and the global enable is 0, so every skip-test query answers 0.
- R2: `irq_req` rises only if some source has its request flag, its enable bit and the global enable all at 1. If any one of the three is 0, the request stays low.
- R3: A request flag is set by its event even while the source is masked, and it stays set. When the masking is later removed, the pending request is taken: `irq_req` rises two clock edges after the cycle in which `gie_set` is presented.
- R4: When several eligible flags are pending, the first source taken is the highest in this fixed order: ext0, ext1, timer1, timer2, timer3, timer4, A/D.
- R5: The source index runs 0 to 6 in the R4 order, and `irq_vec` equals 0x80 + 2 × index (0x80, 0x82, … 0x8C).
- R6: An `irq_ack` presented while `irq_req` is 1 drops `irq_req`, clears the selected source's flag and clears the global enable at the next edge. No further request is raised until `gie_set` is presented again.
- R7: Once raised, `irq_req` and `irq_vec` stay unchanged until acknowledged, even if a higher-priority source becomes pending.
- R8: A skip-test query (`skip_req`=1, `skip_src`=index) on a source with enable bit 0 and flag 1 answers `skip_hit`=1 in the same cycle and clears the flag at the next edge.
- R9: A skip-test query on a source whose enable bit is 1 answers 0 and leaves its flag set. A `skip_src` value of 7 always answers 0.
- R10: An external pin level change in either direction sets that pin's flag at the third clock edge after the change.
- R11: If a flag's event and its clear (skip success or acknowledge) fall in the same cycle, the flag stays 1.
- R12: `gie_set` sets the global enable and `gie_clr` clears it. When both are presented in the same cycle, the clear wins.
- R13: Writing with `en_wr_lo` loads enable bits for ext0, ext1, timer1 and timer2 from `en_wdata` bits 0 to 3. Writing with `en_wr_hi` loads timer3, timer4 and A/D from bits 0 to 2, and bit 3 of that write is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 2 | Asynchronous external pins (bit 0 = ext0) |
| tmr_uf | input | 4 | Timer underflow strobes (bit 0 = timer1) |
| adc_done | input | 1 | A/D completion strobe |
| en_wr_lo | input | 1 | Load low enable register from en_wdata |
| en_wr_hi | input | 1 | Load high enable register from en_wdata |
| en_wdata | input | 4 | Enable register write data |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| irq_ack | input | 1 | Core accepts the pending request |
| skip_req | input | 1 | Skip-test query valid |
| skip_src | input | 3 | Source index of the query |
| skip_hit | output | 1 | Query answer, combinational |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the pending request |

## Verification
Interrupt taking is driven in several ways:
- All seven sources are made pending at once and then taken one at a time. This separates a correct priority order and vector spacing from an off-by-one in either.
- A single source is made pending while it is masked, by its enable bit and by the global flag in turn. This tells a sticky flag apart from an edge-only request.
- A higher-priority source arrives while a request is already raised. This tells a latched vector apart from a recomputed one.

Skip queries are issued on enabled sources, on disabled sources and on the unused code 7. They are also issued in the same cycle as a new event, which shows which of set and clear wins.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int N_EXT = 2;
    localparam int N_TMR = 4;
    localparam int N_SRC = N_EXT + N_TMR + 1;
    localparam int IDX_W = $clog2(N_SRC + 1);
    localparam int REG_W = 4;
    localparam int HI_W  = N_SRC - REG_W;

    typedef logic [IDX_W-1:0] src_idx_t;

    typedef struct packed {
        logic             gie;
        logic [REG_W-1:0] en_lo;
        logic [HI_W-1:0]  en_hi;
        logic             req;
        src_idx_t         sel;
    } ctl_state_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N_PIN  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin,
    output logic [N_PIN-1:0] evt
);
    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
        logic [STAGES:0] sh_q;
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], pin[g]};
        end
        assign evt[g] = sh_q[STAGES] ^ sh_q[STAGES-1];
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic f_q;
        logic f_d;
        // an event in the same cycle as a clear keeps the flag set
        assign f_d = set_i[g] | (f_q & ~clr_i[g]);
        always_ff @(posedge clk) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= f_d;
        end
        assign flag_o[g] = f_q;
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N     = 7,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     cand,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |cand;
        idx = '0;
        // lowest index has the highest priority
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int unsigned VEC_BASE    = 'h80,
    parameter int unsigned VEC_STEP    = 2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic [N_TMR-1:0]  tmr_uf,
    input  logic              adc_done,
    input  logic              en_wr_lo,
    input  logic              en_wr_hi,
    input  logic [REG_W-1:0]  en_wdata,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              irq_ack,
    input  logic              skip_req,
    input  logic [IDX_W-1:0]  skip_src,
    output logic              skip_hit,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vec
);
    ctl_state_t st_q, st_d;

    logic [N_EXT-1:0] ext_evt;
    logic [N_SRC-1:0] evt, flag_q, clr, en_all, elig, skip_oh, ack_oh;
    logic             win_any;
    src_idx_t         win_idx;

    irq_edge_sync #(.N_PIN(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .evt(ext_evt)
    );

    // source order: ext0, ext1, timer1..timer4, A/D
    assign evt    = {adc_done, tmr_uf, ext_evt};
    assign en_all = {st_q.en_hi, st_q.en_lo};

    assign skip_oh = (skip_req && (32'(skip_src) < N_SRC))
                     ? (N_SRC'(1) << skip_src) : '0;
    assign ack_oh  = (irq_ack && st_q.req) ? (N_SRC'(1) << st_q.sel) : '0;
    assign clr     = (skip_oh & ~en_all) | ack_oh;

    irq_flag_bank #(.N(N_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(clr), .flag_o(flag_q)
    );

    assign elig = flag_q & en_all & {N_SRC{st_q.gie}};

    irq_prio_sel #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
        .cand(elig), .any(win_any), .idx(win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (en_wr_lo) st_d.en_lo = en_wdata;
        if (en_wr_hi) st_d.en_hi = en_wdata[HI_W-1:0];
        if (gie_set)  st_d.gie = 1'b1;
        if (gie_clr)  st_d.gie = 1'b0;
        if (st_q.req) begin
            if (irq_ack) begin
                st_d.req = 1'b0;
                st_d.gie = 1'b0;
            end
        end else if (win_any) begin
            st_d.req = 1'b1;
            st_d.sel = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign skip_hit = |(skip_oh & ~en_all & flag_q);
    assign irq_req  = st_q.req;
    assign irq_vec  = ADDR_W'(VEC_BASE + VEC_STEP * 32'(st_q.sel));
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
    parameter int          N_SRC    = 7,
    parameter int          IDX_W    = 3,
    parameter int          ADDR_W   = 8,
    parameter int unsigned VEC_BASE = 'h80,
    parameter int unsigned VEC_STEP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic [ADDR_W-1:0] irq_vec,
    input logic              irq_ack,
    input logic              skip_req,
    input logic [IDX_W-1:0]  skip_src,
    input logic              skip_hit,
    input logic              gie_q,
    input logic [N_SRC-1:0]  en_all,
    input logic [N_SRC-1:0]  flag
);
    logic en_at_src, flag_at_src;
    logic vec_ok;
    assign en_at_src   = en_all[0] & (skip_src == '0) | ((en_all >> skip_src) != '0) & ((en_all >> skip_src) & N_SRC'(1)) != '0;
    assign flag_at_src = ((flag >> skip_src) & N_SRC'(1)) != '0;
    assign vec_ok      = (32'(irq_vec) >= VEC_BASE)
                      && ((32'(irq_vec) - VEC_BASE) < VEC_STEP * N_SRC)
                      && (((32'(irq_vec) - VEC_BASE) % VEC_STEP) == 0);

    // R2
    raise_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gie_q));

    // R5
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> vec_ok);

    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !irq_req && !gie_q);

    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

    // R8
    skip_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_hit |-> skip_req && flag_at_src);

    // R9
    skip_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_hit |-> !en_at_src && (32'(skip_src) < N_SRC));
endmodule

bind irq_vec_ctrl irq_vec_chk #(
    .N_SRC(irq_vec_pkg::N_SRC), .IDX_W(irq_vec_pkg::IDX_W), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .skip_req(skip_req), .skip_src(skip_src),
    .skip_hit(skip_hit), .gie_q(st_q.gie), .en_all(en_all), .flag(flag_q)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin = '0;
    logic [3:0] tmr_uf = '0;
    logic       adc_done = 1'b0;
    logic       en_wr_lo = 1'b0, en_wr_hi = 1'b0;
    logic [3:0] en_wdata = '0;
    logic       gie_set = 1'b0, gie_clr = 1'b0, irq_ack = 1'b0;
    logic       skip_req = 1'b0;
    logic [2:0] skip_src = '0;
    logic       skip_hit, irq_req;
    logic [7:0] irq_vec;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    irq_vec_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_uf(tmr_uf),
        .adc_done(adc_done), .en_wr_lo(en_wr_lo), .en_wr_hi(en_wr_hi),
        .en_wdata(en_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
        .irq_ack(irq_ack), .skip_req(skip_req), .skip_src(skip_src),
        .skip_hit(skip_hit), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_en(input logic [3:0] lo, input logic [3:0] hi);
        en_wr_lo = 1'b1; en_wdata = lo; tick(); en_wr_lo = 1'b0;
        en_wr_hi = 1'b1; en_wdata = hi; tick(); en_wr_hi = 1'b0;
    endtask

    task automatic ei();
        gie_set = 1'b1; tick(); gie_set = 1'b0;
    endtask

    task automatic tpulse(input logic [3:0] tm, input logic ad);
        tmr_uf = tm; adc_done = ad; tick(); tmr_uf = '0; adc_done = 1'b0;
    endtask

    task automatic skip_q(input int src, input bit exp, input string tag);
        skip_req = 1'b1; skip_src = src[2:0];
        #1 chk(skip_hit == exp, tag, skip_hit, exp);
        tick(); skip_req = 1'b0;
    endtask

    task automatic req_low(input string tag);
        chk(irq_req == 1'b0, tag, irq_req, 0);
    endtask

    task automatic take(input int vec, input string tag);
        chk(irq_req == 1'b1, tag, irq_req, 1);
        chk(irq_vec == vec[7:0], tag, irq_vec, vec);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk(irq_req == 1'b0, {tag, " ack"}, irq_req, 0);
    endtask

    task automatic t_reset();
        req_low("R1");
        skip_q(0, 1'b0, "R1");
        skip_q(6, 1'b0, "R1");
    endtask

    task automatic t_mask();
        set_en(4'h0, 4'h0);
        tpulse(4'b0001, 1'b0);
        tick(); tick(); req_low("R2 no enable");
        set_en(4'b0100, 4'h0);
        tick(); req_low("R2 no gie");
        ei(); tick();
        take('h84, "R3");
        tpulse(4'b0001, 1'b0);
        tick(); tick(); req_low("R6 gie cleared by ack");
        ei(); tick();
        take('h84, "R6");
        set_en(4'h0, 4'h0);
        skip_q(2, 1'b0, "R6 flag cleared by ack");
    endtask

    task automatic t_prio();
        set_en(4'hF, 4'h7);
        tpulse(4'hF, 1'b1);
        ext_pin = 2'b11;
        tick(); tick(); tick();
        for (int i = 0; i < 7; i++) begin
            ei(); tick();
            take('h80 + 2 * i, "R4 R5");
        end
        ei(); tick(); req_low("R4 none left");
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
    endtask

    task automatic t_ext();
        set_en(4'h0, 4'h0);
        ext_pin[0] = 1'b0;
        tick(); tick();
        skip_q(0, 1'b0, "R10 not yet");
        skip_q(0, 1'b1, "R10 falling");
        skip_q(0, 1'b0, "R8 consumed");
        ext_pin[1] = 1'b0;
        tick(); tick(); tick();
        skip_q(1, 1'b1, "R10 ext1");
        ext_pin[0] = 1'b1;
        tick(); tick(); tick();
        skip_q(0, 1'b1, "R10 rising");
    endtask

    task automatic t_skip();
        set_en(4'h0, 4'b1010);
        tpulse(4'b1100, 1'b0);
        skip_q(5, 1'b0, "R9 enabled");
        skip_q(4, 1'b1, "R8");
        skip_q(4, 1'b0, "R8 cleared");
        skip_q(7, 1'b0, "R9 code 7");
        set_en(4'h0, 4'h0);
        skip_q(5, 1'b1, "R9 flag kept");
        set_en(4'b1000, 4'h0);
        tpulse(4'b0010, 1'b0);
        skip_q(3, 1'b0, "R13 lo bit3");
        ei(); tick();
        take('h86, "R13");
        set_en(4'h0, 4'b1000);
        tpulse(4'b0000, 1'b1);
        ei(); tick(); req_low("R13 hi bit3 unused");
        skip_q(6, 1'b1, "R13 A/D polled");
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
    endtask

    task automatic t_hold();
        set_en(4'hF, 4'h7);
        ei();
        tpulse(4'b0000, 1'b1);
        tick();
        chk(irq_vec == 8'h8C, "R7 initial", irq_vec, 'h8C);
        tpulse(4'b0001, 1'b0);
        tick(); tick();
        take('h8C, "R7 held");
        ei(); tick();
        take('h84, "R7 next");
    endtask

    task automatic t_setwins();
        set_en(4'h0, 4'h0);
        tpulse(4'b0010, 1'b0);
        tmr_uf = 4'b0010; skip_req = 1'b1; skip_src = 3'd3;
        #1 chk(skip_hit == 1'b1, "R11 hit", skip_hit, 1);
        tick(); tmr_uf = '0; skip_req = 1'b0;
        skip_q(3, 1'b1, "R11 set wins");
        skip_q(3, 1'b0, "R11 then clear");
    endtask

    task automatic t_di();
        set_en(4'hF, 4'h7);
        gie_set = 1'b1; gie_clr = 1'b1; tick(); gie_set = 1'b0; gie_clr = 1'b0;
        tpulse(4'b0001, 1'b0);
        tick(); tick(); req_low("R12 clear wins");
        ei(); tick();
        take('h84, "R12 ei");
        ei();
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
        tpulse(4'b0001, 1'b0);
        tick(); tick(); req_low("R12 di");
        ei(); tick();
        take('h84, "R12 cleanup");
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mask();
        t_prio();
        t_ext();
        t_skip();
        t_hold();
        t_setwins();
        t_di();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule